// File: doc/BRIEF.md
# NAND Controller Register Bank with Key-Protected Configuration

This block is the control and status register file of a NAND flash controller. A host reaches it over a simple 32-bit register bus made of a word offset, a write strobe, a read strobe, write data and combinational read data. It holds the device-interface configuration, the timing word, the interrupt mask, a latched interrupt status, a raw status view of engine levels and the chip-enable mode. The register contents drive the rest of the controller through dedicated outputs.

The configuration and timing registers are guarded by a small lock state machine. It has two states, `LK_LOCKED` and `LK_OPEN`. A key write moves it from `LK_LOCKED` to `LK_OPEN`. In `LK_OPEN`, one write to a guarded register takes effect and returns the machine to `LK_LOCKED`. A lock write with a wrong value also returns it to `LK_LOCKED`. Any other access leaves the state unchanged.

Six hardware event inputs are edge detected and latched into a status register that clears when it is read. A level interrupt is raised while any latched bit is enabled by the mask. Writing the reset code to the command register produces a one-cycle reset request pulse.

Top module: `nand_regbank`

Word offsets: 0 command, 1 lock, 2 interface config, 3 timing, 4 interrupt mask, 5 interrupt status, 6 raw status, 7 chip-enable mode.

## Requirements
- R1: After reset the config, timing, mask and status registers read 0, chip-enable mode reads 1, `ce_normal` is 1, `irq` is 0 and the lock is in `LK_LOCKED`.
- R2: Writing a value whose bits 15:0 are 0xA25E to the lock register (offset 1) opens the guarded registers, config (offset 2) and timing (offset 3). The next write to either of them takes effect. Writes to unguarded registers in between keep the lock open.
- R3: After that single guarded write the lock returns to `LK_LOCKED`, and a further guarded write is ignored.
- R4: A guarded write while locked is ignored. A lock write with any value other than the key leaves the registers locked.
- R5: A rising edge on `evt[i]` sets status bit i (offset 5). The shared mask/status layout is: bit 5 NAND ready, bit 4 controller ready, bit 3 decode failure, bit 2 decode error, bit 1 ECC ready, bit 0 write-protect fault. A level that stays high does not set the bit again.
- R6: A read of the status register returns the latched bits and clears them. An event edge in the same cycle as that read is not returned by it and stays latched.
- R7: `irq` is 1 exactly while (status AND mask) is non-zero. The mask is at offset 4, bits 5:0.
- R8: The raw status register (offset 6) reads `raw_stat[6:0]`, laid out as bit 6 decoder failure, bits 5:4 corrected-error count minus one, bit 3 errors detected, bit 2 ECC ready, bit 1 controller ready, bit 0 NAND ready.
- R9: A command write (offset 0) with bits 7:0 equal to 0xFF raises `rst_pulse` for exactly the cycle after the write. Any other value raises no pulse.
- R10: Bit 0 of the chip-enable register (offset 7) is read/write and drives `ce_normal`. A value of 1 means the controller drives chip-enable itself.
- R11: Config bits 3:0 (write-protect enable, large block, long address, 16-bit bus) appear on `cfg_q`. Config and timing read back as written, and unused read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 3 | Register word offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| evt | input | 6 | Hardware event levels, same bit order as status |
| raw_stat | input | 7 | Engine status levels for the raw status register |
| cfg_q | output | 4 | Interface configuration |
| timing_q | output | 32 | Timing word |
| ce_normal | output | 1 | Chip-enable normal mode |
| irq | output | 1 | Level interrupt |
| rst_pulse | output | 1 | Controller reset request pulse |

## Verification
Two functions can fall in the same cycle: a read of the interrupt status, which clears it, and a new event edge, which sets it. The bench provokes this directly with a directed case, and repeatedly through random event toggling mixed with random status reads. A bench model judges each case: the read must return only the previously latched bits, and the new bit must show on the following read and on `irq`.

// File: rtl/nand_regbank_pkg.sv
package nand_regbank_pkg;
    localparam int OFF_CMD    = 0;
    localparam int OFF_LOCK   = 1;
    localparam int OFF_CFG    = 2;
    localparam int OFF_TIMING = 3;
    localparam int OFF_MASK   = 4;
    localparam int OFF_STAT   = 5;
    localparam int OFF_RAW    = 6;
    localparam int OFF_CE     = 7;

    localparam logic [15:0] UNLOCK_KEY = 16'hA25E;
    localparam logic [7:0]  RESET_CODE = 8'hFF;

    typedef enum logic [0:0] {
        LK_LOCKED = 1'b0,
        LK_OPEN   = 1'b1
    } lock_state_t;
endpackage

// File: rtl/nand_lock_fsm.sv
module nand_lock_fsm
    import nand_regbank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic key_wr,
    input  logic bad_wr,
    input  logic prot_wr,
    output logic open_o
);
    lock_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_LOCKED: if (key_wr) state_d = LK_OPEN;
            LK_OPEN: begin
                if (prot_wr || bad_wr) state_d = LK_LOCKED;
            end
            default: state_d = LK_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        open_o = (state_q == LK_OPEN);
    end
endmodule

// File: rtl/nand_irq_latch.sv
module nand_irq_latch #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         clr,
    input  logic [N-1:0] mask,
    output logic [N-1:0] stat_q,
    output logic         irq
);
    logic [N-1:0] prev_q;
    logic [N-1:0] rise;

    always_comb rise = evt & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            stat_q <= '0;
        end else begin
            prev_q <= evt;
            stat_q <= (clr ? '0 : stat_q) | rise;
        end
    end

    always_comb irq = |(stat_q & mask);
endmodule

// File: rtl/nand_regbank.sv
module nand_regbank
    import nand_regbank_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32,
    parameter int EVT_W  = 6,
    parameter int RAW_W  = 7,
    parameter int CFG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [EVT_W-1:0]  evt,
    input  logic [RAW_W-1:0]  raw_stat,
    output logic [CFG_W-1:0]  cfg_q,
    output logic [DATA_W-1:0] timing_q,
    output logic              ce_normal,
    output logic              irq,
    output logic              rst_pulse
);
    localparam int NREG = 1 << ADDR_W;

    logic [NREG-1:0]  sel;
    logic             open_q;
    logic [EVT_W-1:0] mask_q;
    logic [EVT_W-1:0] stat_q;
    logic             key_match;

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_dec
            assign sel[g] = (bus_addr == ADDR_W'(g));
        end
    endgenerate

    assign key_match = (bus_wdata[15:0] == UNLOCK_KEY);

    nand_lock_fsm u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_wr  (bus_wr && sel[OFF_LOCK] && key_match),
        .bad_wr  (bus_wr && sel[OFF_LOCK] && !key_match),
        .prot_wr (bus_wr && (sel[OFF_CFG] || sel[OFF_TIMING])),
        .open_o  (open_q)
    );

    nand_irq_latch #(.N(EVT_W)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt),
        .clr    (bus_rd && sel[OFF_STAT]),
        .mask   (mask_q),
        .stat_q (stat_q),
        .irq    (irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            timing_q  <= '0;
            mask_q    <= '0;
            ce_normal <= 1'b1;
            rst_pulse <= 1'b0;
        end else begin
            rst_pulse <= bus_wr && sel[OFF_CMD] && (bus_wdata[7:0] == RESET_CODE);
            if (bus_wr && open_q && sel[OFF_CFG])    cfg_q    <= bus_wdata[CFG_W-1:0];
            if (bus_wr && open_q && sel[OFF_TIMING]) timing_q <= bus_wdata;
            if (bus_wr && sel[OFF_MASK])             mask_q   <= bus_wdata[EVT_W-1:0];
            if (bus_wr && sel[OFF_CE])               ce_normal <= bus_wdata[0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (1'b1)
            sel[OFF_CFG]:    bus_rdata = DATA_W'(cfg_q);
            sel[OFF_TIMING]: bus_rdata = timing_q;
            sel[OFF_MASK]:   bus_rdata = DATA_W'(mask_q);
            sel[OFF_STAT]:   bus_rdata = DATA_W'(stat_q);
            sel[OFF_RAW]:    bus_rdata = DATA_W'(raw_stat);
            sel[OFF_CE]:     bus_rdata = DATA_W'(ce_normal);
            default:         bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/nand_regbank_chk.sv
module nand_regbank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  bus_addr,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [31:0] bus_wdata,
    input logic [5:0]  evt,
    input logic [3:0]  cfg_q,
    input logic        open_q,
    input logic [5:0]  stat_q,
    input logic [5:0]  mask_q,
    input logic        irq,
    input logic        rst_pulse
);
    // R2: the lock opens only after a key write
    p_open_needs_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_q) |-> $past(bus_wr && bus_addr == 3'd1 && bus_wdata[15:0] == 16'hA25E));

    // R3: a guarded write in the open state relocks
    p_relock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_wr && bus_addr == 3'd2 && open_q) |-> !open_q);

    // R4: guarded config write while locked leaves config unchanged
    p_locked_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_wr && bus_addr == 3'd2 && !open_q) |-> $stable(cfg_q));

    // R6: after a status read only bits whose event was high remain
    p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd && bus_addr == 3'd5) |-> ((stat_q & ~$past(evt)) == 6'd0));

    // R7: no interrupt with an empty mask
    p_mask_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 6'd0) |-> !irq);

    // R9: reset pulse only after a reset-code command write
    p_pulse_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |-> $past(bus_wr && bus_addr == 3'd0 && bus_wdata[7:0] == 8'hFF));
endmodule

bind nand_regbank nand_regbank_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .evt       (evt),
    .cfg_q     (cfg_q),
    .open_q    (open_q),
    .stat_q    (stat_q),
    .mask_q    (mask_q),
    .irq       (irq),
    .rst_pulse (rst_pulse)
);

// File: tb/sim_nand_regbank.sv
`timescale 1ns/1ps
module sim_nand_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  evt = '0;
    logic [6:0]  raw_stat = '0;
    logic [3:0]  cfg_q;
    logic [31:0] timing_q;
    logic        ce_normal;
    logic        irq;
    logic        rst_pulse;

    int tests = 0;
    int fails = 0;
    logic pulse_seen;
    logic [31:0] rv;
    logic [5:0] m_stat, m_prev, m_mask;

    always #2 clk = ~clk;

    nand_regbank u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt(evt), .raw_stat(raw_stat), .cfg_q(cfg_q), .timing_q(timing_q),
        .ce_normal(ce_normal), .irq(irq), .rst_pulse(rst_pulse)
    );

    function automatic logic exp_irq(input logic [5:0] s, input logic [5:0] m);
        return |(s & m);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = 3'(a); bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1 pulse_seen = rst_pulse;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = 3'(a); bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        fails++; tests++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(2, rv); check("R1 cfg", rv, 0);
        rd(3, rv); check("R1 timing", rv, 0);
        rd(4, rv); check("R1 mask", rv, 0);
        rd(5, rv); check("R1 stat", rv, 0);
        rd(7, rv); check("R1 ce", rv, 1);
        check("R1 irq", {31'd0, irq}, 0);
        // R4 locked and wrong key
        wr(2, 32'hF); rd(2, rv); check("R4 locked cfg", rv, 0);
        wr(1, 32'h1234); wr(2, 32'h5); rd(2, rv); check("R4 bad key", rv, 0);
        // R2/R3/R11
        wr(1, 32'h0000A25E); wr(2, 32'h6); rd(2, rv); check("R2 cfg", rv, 6);
        check("R11 cfg_q", {28'd0, cfg_q}, 6);
        wr(2, 32'h9); rd(2, rv); check("R3 cfg relocked", rv, 6);
        wr(1, 32'hFFFFA25E); wr(3, 32'h01234567); rd(3, rv); check("R2 timing", rv, 32'h01234567);
        check("R11 timing_q", timing_q, 32'h01234567);
        wr(3, 32'h0); rd(3, rv); check("R3 timing relocked", rv, 32'h01234567);
        wr(1, 32'hA25E); wr(4, 32'h3F); wr(2, 32'hA); rd(2, rv); check("R2 open across mask", rv, 32'hA);
        // R8 raw status
        raw_stat = 7'h55; rd(6, rv); check("R8 raw", rv, 32'h55);
        raw_stat = 7'h2A; rd(6, rv); check("R8 raw2", rv, 32'h2A);
        // R9 command pulse
        wr(0, 32'hFF); check("R9 pulse", {31'd0, pulse_seen}, 1);
        @(posedge clk); #1 check("R9 pulse width", {31'd0, rst_pulse}, 0);
        wr(0, 32'h12); check("R9 no pulse", {31'd0, pulse_seen}, 0);
        // R10 chip enable
        wr(7, 0); check("R10 ce off", {31'd0, ce_normal}, 0);
        rd(7, rv); check("R10 ce rd", rv, 0);
        wr(7, 1); check("R10 ce on", {31'd0, ce_normal}, 1);
        // R5/R6/R7 directed
        @(negedge clk); evt = 6'h20;
        @(negedge clk); check("R7 irq set", {31'd0, irq}, 1);
        rd(5, rv); check("R5 stat bit5", rv, 32'h20);
        check("R7 irq cleared", {31'd0, irq}, 0);
        rd(5, rv); check("R5 held level no relatch", rv, 0);
        evt = 6'h00;
        @(negedge clk);
        bus_addr = 3'd5; bus_rd = 1'b1; evt = 6'h02;
        #1 check("R6 same-cycle read old", bus_rdata, 0);
        @(negedge clk); bus_rd = 1'b0; evt = 6'h00;
        rd(5, rv); check("R6 event kept", rv, 32'h02);
        wr(4, 0);
        @(negedge clk); evt = 6'h01;
        @(negedge clk); evt = 6'h00;
        check("R7 masked off", {31'd0, irq}, 0);
        rd(5, rv); check("R5 masked still latched", rv, 32'h01);
        // random phase: R5 R6 R7
        m_mask = 6'($urandom);
        wr(4, {26'd0, m_mask});
        m_stat = '0; m_prev = evt;
        for (int i = 0; i < 400; i++) begin
            logic do_rd;
            logic [5:0] ne;
            @(negedge clk);
            ne = m_prev ^ (($urandom % 3 == 0) ? 6'(1 << ($urandom % 6)) : 6'd0);
            do_rd = ($urandom % 4 == 0);
            evt = ne; bus_addr = 3'd5; bus_rd = do_rd;
            #1;
            if (do_rd) check("R6 random read", bus_rdata, {26'd0, m_stat});
            @(posedge clk);
            m_stat = (do_rd ? 6'd0 : m_stat) | (ne & ~m_prev);
            m_prev = ne;
            #1 check("R7 random irq", {31'd0, irq}, {31'd0, exp_irq(m_stat, m_mask)});
        end
        @(negedge clk); bus_rd = 1'b0;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule